// File: doc/BRIEF.md
# Debounced Contact One-Shot

This block turns a raw, bouncing, active-low contact line into a single clean pulse, one for every closure or, if chosen, one for every opening. A chain of identical debouncing stages does the work. The first stage filters the raw line. Each later stage takes the stage before it as its input, so each tap repeats the one before it a fixed number of sample ticks later. The pulse is high only while the first two taps disagree, with the polarity matching the chosen edge. Its length therefore comes from the delay of the second stage, and no separate counter sets it.

Sampling is paced by a tick enable, so one clock can serve slow contacts. All pins are plain level signals. There is no streaming interface and no back-pressure: the contact is sampled on every ticked cycle, and the pulse and tap levels are valid on every cycle. The taps beyond the second form a multi-tap delay line for the surrounding logic.

Top module: `contact_pulse_gen`

## Requirements
- R1: While and after reset, every tap reads the open level 1 and `pulse` is 0, whatever the raw contact does.
- R2: The first tap takes the raw level on the SAMPLES-th consecutive ticked cycle on which the raw level differs from the tap. A ticked cycle on which they agree restarts that count.
- R3: On a cycle with `tick` low, no tap changes and `pulse` holds its value. Progress already counted is kept and resumes on the next tick.
- R4: Tap k+1 follows tap k exactly SAMPLES ticks later. For a clean closure whose first closed tick is number 1, tap k falls at tick SAMPLES*(k+1).
- R5: With `sel_break` = 0 (make), `pulse` is 1 from the tick on which tap 0 falls until the tick on which tap 1 falls, which is exactly SAMPLES ticks.
- R6: With `sel_break` = 1 (break), `pulse` is 1 from the tick on which tap 0 rises until the tick on which tap 1 rises, which is exactly SAMPLES ticks.
- R7: A raw excursion shorter than SAMPLES ticks changes no tap and gives no pulse. A closure with bounce gives exactly one pulse.
- R8: Only the selected edge fires. In make mode an opening gives no pulse, and in break mode a closure gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample enable; stages advance only on cycles where it is 1 |
| sel_break | input | 1 | 0 = pulse on contact closure, 1 = pulse on contact opening |
| contact_n | input | 1 | Raw contact, 0 = closed, 1 = open |
| pulse | output | 1 | Active-high one-shot, SAMPLES ticks long |
| lead_lvl | output | 1 | Clean level of the first stage (tap 0) |
| lag_lvl | output | 1 | Clean level of the second stage (tap 1) |
| tap_lvl | output | NUM_STAGES | All stage levels, bit k = tap k |

## Verification
Two events can land on the same tick: tap 0 flips back while tap 1 completes its lagged flip. This happens when a closure lasts exactly SAMPLES ticks. The make pulse then ends on the same edge on which the break condition begins. The closure-length sweep covers this with a length of exactly SAMPLES, in both modes and at several tick spacings. Each case is judged by the number of pulse rises, the pulse width in cycles and the edge on which the pulse starts, all computed arithmetically from the closure length and the tick spacing. A second overlap, a frozen tick during a pulse, is judged by the pulse holding and then ending after exactly the remaining ticks.

// File: rtl/contact_pulse_pkg.sv
package contact_pulse_pkg;
  typedef enum logic {
    EDGE_MAKE  = 1'b0,
    EDGE_BREAK = 1'b1
  } edge_sel_e;

  localparam logic LVL_OPEN = 1'b1;
endpackage

// File: rtl/dbp_stage.sv
// One debouncing stage: the output adopts the input level after SAMPLES
// consecutive ticks on which the two disagree.
module dbp_stage
  import contact_pulse_pkg::*;
#(
  parameter int SAMPLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic q
);
  localparam int CW = $clog2(SAMPLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q       <= LVL_OPEN;
      run_cnt <= '0;
    end else if (tick) begin
      if (din == q) begin
        run_cnt <= '0;
      end else if (run_cnt == LAST) begin
        q       <= din;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbp_edge_comb.sv
// Forms the one-shot from the leading and lagging stage levels.
module dbp_edge_comb
  import contact_pulse_pkg::*;
(
  input  logic      lead,
  input  logic      lag,
  input  edge_sel_e mode,
  output logic      pulse
);
  logic want_lead;

  always_comb begin
    want_lead = (mode == EDGE_BREAK) ? 1'b1 : 1'b0;
    pulse     = (lead != lag) && (lead == want_lead);
  end
endmodule

// File: rtl/contact_pulse_gen.sv
module contact_pulse_gen
  import contact_pulse_pkg::*;
#(
  parameter int SAMPLES    = 4,
  parameter int NUM_STAGES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  sel_break,
  input  logic                  contact_n,
  output logic                  pulse,
  output logic                  lead_lvl,
  output logic                  lag_lvl,
  output logic [NUM_STAGES-1:0] tap_lvl
);
  logic [NUM_STAGES:0] link;
  edge_sel_e           mode;

  assign link[0] = contact_n;
  assign mode    = edge_sel_e'(sel_break);

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    dbp_stage #(.SAMPLES(SAMPLES)) u_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .din  (link[g]),
      .q    (link[g+1])
    );
  end

  assign tap_lvl  = link[NUM_STAGES:1];
  assign lead_lvl = link[1];
  assign lag_lvl  = link[2];

  dbp_edge_comb u_edge (
    .lead (lead_lvl),
    .lag  (lag_lvl),
    .mode (mode),
    .pulse(pulse)
  );
endmodule

// File: rtl/contact_pulse_gen_chk.sv
module contact_pulse_gen_chk #(
  parameter int SAMPLES    = 4,
  parameter int NUM_STAGES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  sel_break,
  input logic                  pulse,
  input logic [NUM_STAGES-1:0] tap_lvl
);
  localparam int PW = $clog2(SAMPLES + 2);
  localparam logic [PW-1:0] CAP = PW'(SAMPLES + 1);

  logic [PW-1:0] pulse_ticks;

  always_ff @(posedge clk) begin
    if (!rst_n || !pulse) pulse_ticks <= '0;
    else if (tick && pulse_ticks != CAP) pulse_ticks <= pulse_ticks + 1'b1;
  end

  a_r3_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(tap_lvl) && $stable(pulse)));

  for (genvar k = 1; k < NUM_STAGES; k++) begin : g_follow
    a_r4_tap_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tap_lvl[k]) |-> (tap_lvl[k] == $past(tap_lvl[k-1])));
  end

  a_r5_make_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_break && pulse) |-> (!tap_lvl[0] && tap_lvl[1]));

  a_r6_break_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_break && pulse) |-> (tap_lvl[0] && !tap_lvl[1]));

  // R5 and R6: the pulse never outlasts SAMPLES ticks
  a_r5_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_ticks <= PW'(SAMPLES));

  a_r8_pulse_needs_disagree: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (tap_lvl[0] != tap_lvl[1]));
endmodule

bind contact_pulse_gen contact_pulse_gen_chk #(
  .SAMPLES   (SAMPLES),
  .NUM_STAGES(NUM_STAGES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .sel_break(sel_break),
  .pulse    (pulse),
  .tap_lvl  (tap_lvl)
);

// File: tb/contact_pulse_gen_bench.sv
`timescale 1ns/100ps
module contact_pulse_gen_bench;
  localparam int D  = 4;
  localparam int NS = 4;
  localparam int TOT = 48 + D * NS;

  logic clk = 1'b0;
  logic rst_n, tick, sel_break, contact_n;
  logic pulse, lead_lvl, lag_lvl;
  logic [NS-1:0] tap_lvl;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  contact_pulse_gen #(.SAMPLES(D), .NUM_STAGES(NS)) u_contact_pulse_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel_break(sel_break),
    .contact_n(contact_n), .pulse(pulse), .lead_lvl(lead_lvl),
    .lag_lvl(lag_lvl), .tap_lvl(tap_lvl)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic raw);
    tick = t;
    contact_n = raw;
    @(posedge clk);
    #1;
  endtask

  // pat bit t-1 = 1 means contact closed on tick t. P = cycles per tick.
  // exp_f: tick on which tap 0 falls (0 = never). exp_rise: tick of the
  // pulse start in this mode (0 = no pulse).
  task automatic run_seg(input logic [63:0] pat, input int P, input bit sel,
                         input int exp_f, input int exp_rise, input string req);
    int rises = 0, hi = 0, first = -1, c = 0;
    int fall[NS];
    logic prev = 1'b0;
    for (int k = 0; k < NS; k++) fall[k] = -1;
    sel_break = sel;
    for (int t = 1; t <= TOT; t++) begin
      for (int s = 1; s <= P; s++) begin
        cyc(s == P, (t <= 64 && pat[t-1]) ? 1'b0 : 1'b1);
        c++;
        if (pulse && !prev) begin
          rises++;
          if (first < 0) first = c;
        end
        if (pulse) hi++;
        prev = pulse;
        for (int k = 0; k < NS; k++)
          if (fall[k] < 0 && !tap_lvl[k]) fall[k] = c;
      end
    end
    chk(rises == (exp_rise > 0 ? 1 : 0), req, "pulse count", rises, exp_rise > 0 ? 1 : 0);
    chk(hi == (exp_rise > 0 ? D * P : 0), req, "pulse width cycles", hi, exp_rise > 0 ? D * P : 0);
    if (exp_rise > 0)
      chk(first == exp_rise * P, req, "pulse start cycle", first, exp_rise * P);
    for (int k = 0; k < NS; k++) begin
      int e = (exp_f > 0) ? (exp_f + D * k) * P : -1;
      chk(fall[k] == e, (k == 0) ? "R2" : "R4", $sformatf("tap %0d fall cycle", k), fall[k], e);
    end
    chk(tap_lvl == {NS{1'b1}}, "R1", "idle taps after segment", tap_lvl, (1 << NS) - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel_break = 1'b0;
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0);
    // R1: reset state with the contact held closed
    chk(tap_lvl == {NS{1'b1}}, "R1", "taps in reset", tap_lvl, (1 << NS) - 1);
    chk(pulse == 1'b0, "R1", "pulse in reset", pulse, 0);
    chk(lead_lvl && lag_lvl, "R1", "stage levels in reset", {lead_lvl, lag_lvl}, 3);
    rst_n = 1'b1;
    cyc(1'b1, 1'b1);
    chk(tap_lvl == {NS{1'b1}} && !pulse, "R1", "after reset", tap_lvl, (1 << NS) - 1);

    // R3: a closed contact without ticks changes nothing
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0);
    chk(tap_lvl == {NS{1'b1}}, "R3", "taps with no tick", tap_lvl, (1 << NS) - 1);
    chk(pulse == 1'b0, "R3", "pulse with no tick", pulse, 0);

    // R3: freeze in the middle of a make pulse
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0);
    chk(tap_lvl == 4'b1110 && pulse, "R5", "pulse running at tick 6", tap_lvl, 4'b1110);
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1);
    chk(tap_lvl == 4'b1110, "R3", "taps frozen", tap_lvl, 4'b1110);
    chk(pulse == 1'b1, "R3", "pulse frozen", pulse, 1);
    cyc(1'b1, 1'b1);
    chk(pulse == 1'b1, "R3", "pulse one tick after resume", pulse, 1);
    cyc(1'b1, 1'b1);
    chk(pulse == 1'b0, "R3", "pulse ends after remaining ticks", pulse, 0);
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b1);
    chk(tap_lvl == {NS{1'b1}}, "R3", "drained", tap_lvl, (1 << NS) - 1);

    // R5, R6, R7, R8: closure-length sweep, both modes, three tick spacings
    for (int sel = 0; sel < 2; sel++)
      for (int P = 1; P <= 3; P++)
        for (int L = 1; L <= 12; L++) begin
          logic [63:0] pat = (64'd1 << L) - 64'd1;
          int f = (L >= D) ? D : 0;
          int r = (L < D) ? 0 : (sel ? L + D : D);
          run_seg(pat, P, sel[0], f, r, (L < D) ? "R7" : (sel ? "R6" : "R5"));
        end

    // R7: bouncing closure gives one pulse; R8: bouncing release in make mode
    for (int P = 1; P <= 2; P++) begin
      logic [63:0] pat = 64'h07FF_FFFF & ~64'h0000_0044;
      run_seg(pat, P, 1'b0, 11, 11, "R7");
    end
    begin
      logic [63:0] pat = 64'h0000_1BFF;
      run_seg(pat, 1, 1'b0, 4, 4, "R8");
      run_seg(pat, 2, 1'b1, 4, 17, "R6");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule